// File: doc/BRIEF.md
# Bit-Plane Sample Transposer

The block takes a capture stream in which every 16-bit word holds sixteen successive samples of a single logic channel. It turns that stream into 16-bit parallel samples that carry one bit per channel. Bytes arrive one per handshake and are paired little-endian into words. Each word belongs to a rotation slot. Every slot has a programmable one-hot mask that names the output bit for its channel. The mask is ORed into every output sample whose time position is set in the word.

Sixteen sample accumulators collect the contributions. When every enabled channel has supplied its word, the accumulators are released as a 16-word burst on a valid/ready output and then cleared. The input is stalled while the burst drains. The slot position carries over from one packet to the next, so a channel round may cross packet boundaries. A packet with an odd number of bytes raises a one-cycle error pulse, and its unpaired final byte is dropped.

Top module: `bitplane_xpose`

## Requirements
- R1: Two consecutive accepted bytes of a packet form one word. The earlier byte is bits 7:0 and the later byte is bits 15:8.
- R2: Word bit 15 is output sample 0 (the earliest) and word bit 0 is output sample 15. Samples leave the block in order 0 to 15.
- R3: A word received in slot k ORs the slot-k mask into every output sample whose bit in the word is set. Contributions from different slots, and overlapping masks, accumulate by OR.
- R4: After as many words as the channel count, the slot returns to 0. Exactly 16 output words are then presented, and the next round starts from cleared accumulators.
- R5: The slot position is kept across packet boundaries.
- R6: A byte that carries the packet-end marker while it would be the low byte of a word produces a one-cycle `odd_err` pulse in the following cycle, and that byte is discarded. A byte flagged as packet start is always taken as a low byte.
- R7: `in_ready` is low exactly while a burst is pending. While `out_valid` is high and `out_ready` is low, `out_word` and `out_valid` hold.
- R8: A count write of 1 to 16 sets the channel count. Any other count value is ignored. The count is 16 after reset.
- R9: Configuration writes take effect only when no burst is pending and the slot is 0. Writes at other times are ignored.
- R10: After reset `out_valid` and `odd_err` are low, `in_ready` is high, and slot k's mask is 1 << k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Input byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_word | output | 16 | Parallel sample, one bit per channel |
| odd_err | output | 1 | Pulse: packet ended on an unpaired byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_count | input | 1 | 1: write channel count, 0: write a slot mask |
| cfg_slot | input | 4 | Slot whose mask is written |
| cfg_data | input | 16 | Mask or count value |

## Verification
On every cycle the assertions check the following:
- the output holds under backpressure;
- no word is absorbed during a burst;
- the slot wraps and the burst starts on the last word of a round;
- the burst ends after its sixteenth transfer;
- the channel count stays in range;
- configuration stays frozen while mid-round or draining;
- an error pulse is always preceded by an accepted packet end.

The actual sample values can only be shown by the bench's scenarios. These values are the transposed bit order, the mask merging, rounds that span packets, dropped odd bytes and ignored configuration writes. The bench compares each burst word against a behavioural model.

// File: rtl/bpx_pkg.sv
package bpx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = WORD_W / 2;
  localparam int unsigned SLOT_W = $clog2(WORD_W);
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // earlier byte is the low half
  function automatic word_t join_bytes(input byte_t first_b, input byte_t second_b);
    return {second_b, first_b};
  endfunction

  // sample s is carried in word bit (WORD_W-1-s): MSB is the earliest
  function automatic int unsigned bit_for_sample(input int unsigned s);
    return WORD_W - 1 - s;
  endfunction

  function automatic logic count_ok(input word_t v);
    return (v != '0) && (v <= word_t'(WORD_W));
  endfunction
endpackage

// File: rtl/bpx_byte_pair.sv
module bpx_byte_pair
  import bpx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  sop,
  input  logic  eop,
  input  byte_t din,
  output logic  word_stb,
  output word_t word,
  output logic  odd_err
);
  logic  phase_q;
  byte_t lo_q;
  logic  start_low;

  assign start_low = sop || !phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lo_q    <= '0;
      odd_err <= 1'b0;
    end else begin
      odd_err <= 1'b0;
      if (take) begin
        if (start_low) begin
          lo_q    <= din;
          phase_q <= !eop;
          odd_err <= eop;
        end else begin
          phase_q <= 1'b0;
        end
      end
    end
  end

  assign word_stb = take && !start_low;
  assign word     = join_bytes(lo_q, din);

  // R6
  odd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odd_err |-> $past(take && eop));
endmodule

// File: rtl/bpx_cfg.sv
module bpx_cfg
  import bpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              is_count,
  input  logic [SLOT_W-1:0] slot_sel,
  input  word_t             data,
  input  logic              idle,
  input  logic [SLOT_W-1:0] rd_slot,
  output word_t             rd_mask,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0][WORD_W-1:0] mask_q;
  logic [CNT_W-1:0]              count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WORD_W; k++) mask_q[k] <= word_t'(1) << k;
      count_q <= CNT_W'(WORD_W);
    end else if (we && idle) begin
      if (is_count) begin
        if (count_ok(data)) count_q <= CNT_W'(data);
      end else begin
        mask_q[slot_sel] <= data;
      end
    end
  end

  assign rd_mask = mask_q[rd_slot];
  assign count   = count_q;

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != '0) && (count_q <= CNT_W'(WORD_W)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(count_q) && $stable(mask_q)));
endmodule

// File: rtl/bpx_accum.sv
module bpx_accum
  import bpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  word_t             word,
  input  word_t             mask,
  input  logic [CNT_W-1:0]  count,
  input  logic              out_ready,
  output logic [SLOT_W-1:0] slot,
  output logic              out_valid,
  output word_t             out_word,
  output logic              in_ready,
  output logic              idle
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] idx_q;
  logic              draining_q;
  logic              last_slot;
  logic              pop;
  logic              last_pop;
  word_t             acc [WORD_W];

  assign last_slot = (CNT_W'(slot_q) == (count - CNT_W'(1)));
  assign pop       = draining_q && out_ready;
  assign last_pop  = pop && (idx_q == SLOT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q     <= '0;
      idx_q      <= '0;
      draining_q <= 1'b0;
    end else begin
      if (word_stb) begin
        slot_q <= last_slot ? '0 : slot_q + SLOT_W'(1);
        if (last_slot) draining_q <= 1'b1;
      end else if (last_pop) begin
        draining_q <= 1'b0;
      end
      if (last_pop)      idx_q <= '0;
      else if (pop)      idx_q <= idx_q + SLOT_W'(1);
    end
  end

  for (genvar g = 0; g < WORD_W; g++) begin : g_lane
    localparam int unsigned BITPOS = bit_for_sample(g);
    word_t lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  lane_q <= '0;
      else if (word_stb && word[BITPOS])           lane_q <= lane_q | mask;
      else if (pop && (idx_q == SLOT_W'(g)))       lane_q <= '0;
    end
    assign acc[g] = lane_q;
  end

  assign slot      = slot_q;
  assign out_valid = draining_q;
  assign out_word  = acc[idx_q];
  assign in_ready  = !draining_q;
  assign idle      = !draining_q && (slot_q == '0);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R7
  no_take_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> !out_valid);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && last_slot) |=> (out_valid && (slot_q == '0)));

  // R4
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_pop |=> !out_valid);

  // R8
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(slot_q) < count);
endmodule

// File: rtl/bitplane_xpose.sv
module bitplane_xpose
  import bpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              odd_err,
  input  logic              cfg_we,
  input  logic              cfg_is_count,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [WORD_W-1:0] cfg_data
);
  logic              take;
  logic              word_stb;
  word_t             word;
  word_t             cur_mask;
  logic [CNT_W-1:0]  count;
  logic [SLOT_W-1:0] slot;
  logic              idle;

  assign take = in_valid && in_ready;

  bpx_byte_pair u_pair (
    .clk(clk), .rst_n(rst_n), .take(take), .sop(in_sop), .eop(in_eop),
    .din(in_byte), .word_stb(word_stb), .word(word), .odd_err(odd_err)
  );

  bpx_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .is_count(cfg_is_count),
    .slot_sel(cfg_slot), .data(cfg_data), .idle(idle), .rd_slot(slot),
    .rd_mask(cur_mask), .count(count)
  );

  bpx_accum u_acc (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word(word), .mask(cur_mask),
    .count(count), .out_ready(out_ready), .slot(slot), .out_valid(out_valid),
    .out_word(out_word), .in_ready(in_ready), .idle(idle)
  );
endmodule

// File: tb/bitplane_xpose_tb.sv
module bitplane_xpose_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop, in_ready;
  logic [7:0]  in_byte;
  logic        out_valid, out_ready, odd_err;
  logic [15:0] out_word;
  logic        cfg_we, cfg_is_count;
  logic [3:0]  cfg_slot;
  logic [15:0] cfg_data;

  int checks = 0;
  int fails  = 0;
  string tag = "R10";

  // behavioural model
  int          m_count = 16;
  logic [15:0] m_mask [16];
  int          m_slot = 0;
  logic [15:0] m_acc [16];
  bit          m_phase = 0;
  logic [7:0]  m_lo;
  bit          err_due = 0;
  logic [15:0] exp_q [$];
  bit          held = 0;
  logic [15:0] held_word;

  always #5 clk = ~clk;

  bitplane_xpose u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .odd_err(odd_err),
    .cfg_we(cfg_we), .cfg_is_count(cfg_is_count), .cfg_slot(cfg_slot),
    .cfg_data(cfg_data)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s): got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  function automatic void model_word(input logic [15:0] w);
    for (int s = 0; s < 16; s++)
      if (w[15 - s]) m_acc[s] = m_acc[s] | m_mask[m_slot];
    m_slot++;
    if (m_slot == m_count) begin
      for (int s = 0; s < 16; s++) begin
        exp_q.push_back(m_acc[s]);
        m_acc[s] = '0;
      end
      m_slot = 0;
    end
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit sop, input bit eop);
    bit got;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_sop = sop; in_eop = eop;
    got = 0;
    while (!got) begin
      got = in_ready;
      @(posedge clk); #1;
      if (!got) @(negedge clk);
    end
    in_valid = 1'b0;
    if (sop) m_phase = 0;
    if (!m_phase) begin
      m_lo = b;
      if (eop) begin err_due = 1; m_phase = 0; end
      else m_phase = 1;
    end else begin
      model_word({b, m_lo});
      m_phase = 0;
    end
  endtask

  task automatic send_pkt(input int n);
    for (int i = 0; i < n; i++) send_byte(8'($urandom), i == 0, i == n - 1);
  endtask

  task automatic cfg_write(input bit is_cnt, input int slot, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_is_count = is_cnt; cfg_slot = 4'(slot); cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (m_slot == 0) begin
      if (is_cnt) begin
        if (d >= 1 && d <= 16) m_count = int'(d);
      end else m_mask[slot] = d;
    end
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // output readiness changes away from the edges
  always @(posedge clk) begin
    #2;
    out_ready = rst_n && (($urandom % 4) != 0);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready === !out_valid, "R7 in_ready vs burst", {31'b0, in_ready}, {31'b0, !out_valid});
      if (out_valid && held)
        chk(out_word === held_word, "R7 hold under backpressure", {16'b0, out_word}, {16'b0, held_word});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R4 unexpected output word", {16'b0, out_word}, 32'b0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(out_word === e, "R1/R2/R3/R4 sample word", {16'b0, out_word}, {16'b0, e});
        end
        held = 0;
      end else if (out_valid) begin
        held = 1; held_word = out_word;
      end else held = 0;
      if (err_due || odd_err)
        chk(odd_err === err_due, "R6 odd_err", {31'b0, odd_err}, {31'b0, err_due});
      err_due = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'b0, 32'b1);
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin m_mask[k] = 16'(1) << k; m_acc[k] = '0; end
    rst_n = 0; in_valid = 0; in_byte = 0; in_sop = 0; in_eop = 0; out_ready = 0;
    cfg_we = 0; cfg_is_count = 0; cfg_slot = 0; cfg_data = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    tag = "R10";
    chk(out_valid === 1'b0, "R10 out_valid", {31'b0, out_valid}, 32'b0);
    chk(in_ready === 1'b1, "R10 in_ready", {31'b0, in_ready}, 32'b1);
    chk(odd_err === 1'b0, "R10 odd_err", {31'b0, odd_err}, 32'b0);

    // default 16 channels with identity masks (R10, R1, R2, R3, R4)
    tag = "R10 default";
    send_pkt(32);
    wait_drain();

    // single channel, directed bit order: word 0x8001 (R1, R2, R8)
    tag = "R2 order";
    cfg_write(1, 0, 16'd1);
    cfg_write(0, 0, 16'h0001);
    send_byte(8'h01, 1, 0);
    send_byte(8'h80, 0, 1);
    wait_drain();

    // three channels, rounds straddling packets (R5, R3)
    tag = "R5 straddle";
    cfg_write(1, 0, 16'd3);
    cfg_write(0, 0, 16'h0100);
    cfg_write(0, 1, 16'h0001);
    cfg_write(0, 2, 16'h8000);
    for (int p = 0; p < 3; p++) send_pkt(4);
    wait_drain();

    // overlapping masks accumulate by OR (R3)
    tag = "R3 overlap";
    cfg_write(1, 0, 16'd2);
    cfg_write(0, 0, 16'h00F0);
    cfg_write(0, 1, 16'h0F10);
    send_pkt(4);
    send_pkt(4);
    wait_drain();

    // odd packets and packet-start resync (R6)
    tag = "R6 odd";
    send_pkt(3);
    send_pkt(2);
    send_pkt(1);
    send_byte(8'hA5, 1, 0);
    send_pkt(2);
    send_pkt(2);
    wait_drain();

    // out-of-range counts ignored (R8)
    tag = "R8 count";
    cfg_write(1, 0, 16'd0);
    cfg_write(1, 0, 16'd17);
    send_pkt(4);
    wait_drain();

    // configuration frozen mid-round (R9)
    tag = "R9 frozen";
    cfg_write(1, 0, 16'd3);
    send_pkt(2);
    cfg_write(0, 1, 16'hFFFF);
    cfg_write(1, 0, 16'd1);
    send_pkt(4);
    wait_drain();

    // full-width boundary again (R8)
    tag = "R8 sixteen";
    cfg_write(1, 0, 16'd16);
    send_pkt(32);
    wait_drain();

    tag = "R4 end";
    chk(exp_q.size() == 0, "R4 all bursts delivered", exp_q.size(), 32'b0);
    chk(in_ready === 1'b1, "R7 idle ready", {31'b0, in_ready}, 32'b1);
    summary();
    $finish;
  end
endmodule